// File: doc/BRIEF.md
# Glitch-Free System Clock Selector

This block picks the system clock from three free-running sources: a fast primary oscillator, a slow secondary oscillator and an internal oscillator. A two-bit select code, held in a software register outside the block, names the wanted source. A static configuration bit decides whether code 00 means the primary or the internal oscillator, so the same bit also fixes the clock in use after reset. Until the configuration-loaded flag goes high, the internal oscillator drives the output whatever the other inputs say.

A switch is a handshake. The outgoing source's enable drops on that clock's falling edge, and only after the drop has been seen does the incoming source's enable rise on its own falling edge. The output therefore pauses low for about two old cycles plus three new cycles and never shows a runt phase. The controller, which runs on the internal oscillator, accepts a new target only once the previous handover is complete. The primary source is held back by a start-up timer. Two status flags report whether the primary or the secondary source is the one now driving the output.

Top module: `sysclk_switch`

## Requirements
- R1: While `por_n` is low, `sys_clk`, `pri_active` and `sec_active` are all low. From reset until `cfg_loaded` first goes high, `sys_clk` follows `clk_int` and both flags stay low, whatever `sel`, `pri_default` and `sec_osc_en` hold.
- R2: Select code 00 chooses the primary oscillator when `pri_default` is 1 and the internal oscillator when `pri_default` is 0.
- R3: Select code 01 with `sec_osc_en` high chooses the secondary oscillator, and `sec_active` is high while it drives `sys_clk`.
- R4: Select codes 10 and 11 both choose the internal oscillator, with `pri_active` and `sec_active` low.
- R5: Select code 01 while `sec_osc_en` is low is ignored: the source in use before the request keeps driving `sys_clk`.
- R6: The primary source is released only after `OST_CYCLES` primary-clock cycles have passed since reset. While it is wanted but not yet released, `sys_clk` is held low with no edges and `pri_active` is low. `pri_active` is high only while the primary source drives `sys_clk`.
- R7: Handover is glitch-free. No high or low phase of `sys_clk` is shorter than the shortest half-period among the sources, and a source enable rises only while every other source enable is low.
- R8: At no time are `pri_active` and `sec_active` both high, and at most one source is enabled onto `sys_clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_int | input | 1 | Internal oscillator; also clocks the controller |
| clk_pri | input | 1 | Primary oscillator |
| clk_sec | input | 1 | Secondary low-speed oscillator |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| sel | input | 2 | Source select code (00 default, 01 secondary, 10/11 internal) |
| pri_default | input | 1 | Configuration bit: 1 maps code 00 to primary, 0 maps it to internal |
| sec_osc_en | input | 1 | Secondary oscillator enabled; a secondary request needs it high |
| cfg_loaded | input | 1 | Configuration values valid; the select path is live once it is high |
| sys_clk | output | 1 | Gated, glitch-free system clock |
| pri_active | output | 1 | Primary oscillator drives `sys_clk` |
| sec_active | output | 1 | Secondary oscillator drives `sys_clk` |

## Verification
The bench runs every combination of configuration bit, select code and secondary enable, starting each time from the primary source. It identifies the driving source by measuring the output period and reads the flags at the same moment, so a design that dropped the secondary-enable guard would be seen to leave the primary clock when it should stay on it. A dedicated sequence requests the primary source before its start-up timer has run out: a design that released it early would show 8 ns edges while the output should still be silent. An edge-to-edge monitor watches every output phase for the whole run, so a design that moved an enable on a rising edge, or overlapped two sources, would leave a short phase behind.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;

  localparam int unsigned NUM_SRC = 3;

  // Index of each source in the per-source vectors.
  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_PRI = 2'd1,
    SRC_SEC = 2'd2
  } src_e;

  // Select code to source, with the default code remapped by the config bit.
  function automatic src_e decode_sel(input logic [1:0] code, input logic pri_dflt);
    src_e res;
    case (code)
      2'b00:   res = pri_dflt ? SRC_PRI : SRC_INT;
      2'b01:   res = SRC_SEC;
      default: res = SRC_INT;
    endcase
    return res;
  endfunction

  function automatic logic [NUM_SRC-1:0] src_onehot(input src_e s);
    logic [NUM_SRC-1:0] res;
    res = '0;
    res[s] = 1'b1;
    return res;
  endfunction

endpackage

// File: rtl/clksel_sync.sv
`timescale 1ns/1ps
// Multi-stage flop synchronizer, one chain per bit.
module clksel_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_in;
    for (int k = 1; k < STAGES; k++) begin
      stage_d[k] = stage_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) begin
        stage_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < STAGES; k++) begin
        stage_q[k] <= stage_d[k];
      end
    end
  end

  assign q_out = stage_q[STAGES-1];

endmodule

// File: rtl/clksel_rst_sync.sv
`timescale 1ns/1ps
// Reset bridge: asserts at once, releases after STAGES edges of clk.
module clksel_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/clksel_ost.sv
`timescale 1ns/1ps
// Start-up timer on the primary oscillator: counts CYCLES edges after reset.
module clksel_ost #(
  parameter int unsigned CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);

  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == LIMIT);
  assign cnt_en = !done;
  assign cnt_d  = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/clksel_chan.sv
`timescale 1ns/1ps
// One source lane: synchronize the request, then move the enable on the
// falling edge so the gated clock only changes while its source is low.
module clksel_chan #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  input  logic gate,
  output logic en
);

  logic req_s;
  logic en_d;
  logic en_q;

  clksel_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (req_async),
    .q_out (req_s)
  );

  assign en_d = req_s & gate;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign en = en_q;

endmodule

// File: rtl/clksel_ctrl.sv
`timescale 1ns/1ps
// Target selection on the internal oscillator. A new target is taken only
// when the lane enables, seen through synchronizers, show the current target
// alone, so no two lanes are ever in flight at once.
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         sel_in,
  input  logic               pri_dflt_in,
  input  logic               sec_en_in,
  input  logic               loaded_in,
  input  logic [NUM_SRC-1:0] en_async,
  output src_e               tgt,
  output logic               loaded,
  output logic               sec_en_sync
);

  localparam int unsigned CTL_W = 5;
  localparam int unsigned SW    = CTL_W + NUM_SRC;

  logic [SW-1:0]      raw;
  logic [SW-1:0]      synced;
  logic [1:0]         sel_s;
  logic               pri_s;
  logic               ld_s;
  logic [NUM_SRC-1:0] en_s;

  src_e tgt_q, tgt_d, want;
  logic loaded_q, loaded_d;
  logic settled;

  assign raw = {en_async, loaded_in, sec_en_in, pri_dflt_in, sel_in};

  clksel_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (raw),
    .q_out (synced)
  );

  assign sel_s       = synced[1:0];
  assign pri_s       = synced[2];
  assign sec_en_sync = synced[3];
  assign ld_s        = synced[4];
  assign en_s        = synced[SW-1:CTL_W];

  assign want     = decode_sel(sel_s, pri_s);
  assign settled  = (en_s == src_onehot(tgt_q));
  assign loaded_d = loaded_q | ld_s;

  always_comb begin
    tgt_d = tgt_q;
    if (settled) begin
      if (!loaded_q) begin
        tgt_d = SRC_INT;
      end else if ((want == SRC_SEC) && !sec_en_sync) begin
        tgt_d = tgt_q;
      end else begin
        tgt_d = want;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q    <= SRC_INT;
      loaded_q <= 1'b0;
    end else begin
      tgt_q    <= tgt_d;
      loaded_q <= loaded_d;
    end
  end

  assign tgt    = tgt_q;
  assign loaded = loaded_q;

endmodule

// File: rtl/sysclk_switch.sv
`timescale 1ns/1ps
module sysclk_switch
  import clksel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OST_CYCLES  = 1024
) (
  input  logic       clk_int,
  input  logic       clk_pri,
  input  logic       clk_sec,
  input  logic       por_n,
  input  logic [1:0] sel,
  input  logic       pri_default,
  input  logic       sec_osc_en,
  input  logic       cfg_loaded,
  output logic       sys_clk,
  output logic       pri_active,
  output logic       sec_active
);

  localparam int unsigned INT_IDX = 32'(SRC_INT);
  localparam int unsigned PRI_IDX = 32'(SRC_PRI);
  localparam int unsigned SEC_IDX = 32'(SRC_SEC);

  logic [NUM_SRC-1:0] clk_v;
  logic [NUM_SRC-1:0] rst_n_v;
  logic [NUM_SRC-1:0] en_vec;
  logic [NUM_SRC-1:0] req_v;
  logic [NUM_SRC-1:0] gate_v;
  src_e               tgt_src;
  logic               loaded_q;
  logic               sec_en_s;
  logic               ost_done;

  assign clk_v[INT_IDX] = clk_int;
  assign clk_v[PRI_IDX] = clk_pri;
  assign clk_v[SEC_IDX] = clk_sec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam src_e MY_SRC = src_e'(2'(i));
    logic [NUM_SRC-1:0] others;

    clksel_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk   (clk_v[i]),
      .por_n (por_n),
      .rst_n (rst_n_v[i])
    );

    assign others   = en_vec & ~src_onehot(MY_SRC);
    assign req_v[i] = (tgt_src == MY_SRC) && (others == '0);

    if (MY_SRC == SRC_PRI) begin : g_timer_gate
      assign gate_v[i] = ost_done;
    end else begin : g_open_gate
      assign gate_v[i] = 1'b1;
    end

    clksel_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk       (clk_v[i]),
      .rst_n     (rst_n_v[i]),
      .req_async (req_v[i]),
      .gate      (gate_v[i]),
      .en        (en_vec[i])
    );
  end

  clksel_ost #(.CYCLES(OST_CYCLES)) u_ost (
    .clk   (clk_pri),
    .rst_n (rst_n_v[PRI_IDX]),
    .done  (ost_done)
  );

  clksel_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk         (clk_int),
    .rst_n       (rst_n_v[INT_IDX]),
    .sel_in      (sel),
    .pri_dflt_in (pri_default),
    .sec_en_in   (sec_osc_en),
    .loaded_in   (cfg_loaded),
    .en_async    (en_vec),
    .tgt         (tgt_src),
    .loaded      (loaded_q),
    .sec_en_sync (sec_en_s)
  );

  assign sys_clk    = |(clk_v & en_vec);
  assign pri_active = en_vec[PRI_IDX];
  assign sec_active = en_vec[SEC_IDX];

endmodule

// File: rtl/sysclk_switch_chk.sv
`timescale 1ns/1ps
module sysclk_switch_chk
  import clksel_pkg::*;
(
  input logic [NUM_SRC-1:0] clk_v,
  input logic [NUM_SRC-1:0] rst_v,
  input logic [NUM_SRC-1:0] en_vec,
  input logic [1:0]         tgt,
  input logic               loaded,
  input logic               sec_en_s,
  input logic               ost_done,
  input logic               pri_active,
  input logic               sec_active
);

  AST_SINGLE_SOURCE: assert property (@(posedge clk_v[0]) disable iff (!rst_v[0])
    ($countones(en_vec) <= 1) && $onehot0({pri_active, sec_active})); // R8

  AST_PRI_AFTER_TIMER: assert property (@(posedge clk_v[1]) disable iff (!rst_v[1])
    pri_active |-> ost_done); // R6

  AST_INT_UNTIL_LOADED: assert property (@(posedge clk_v[0]) disable iff (!rst_v[0])
    !loaded |-> (!pri_active && !sec_active)); // R1

  AST_SEC_NEEDS_ENABLE: assert property (@(posedge clk_v[0]) disable iff (!rst_v[0])
    ((tgt == SRC_SEC) && ($past(tgt) != SRC_SEC)) |-> $past(sec_en_s)); // R5

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_dom
    AST_CLEAN_HANDOVER: assert property (@(posedge clk_v[i]) disable iff (!rst_v[i])
      $rose(en_vec[i]) |-> ((en_vec & ~(3'b001 << i)) == 3'b000)); // R7
  end

endmodule

bind sysclk_switch sysclk_switch_chk u_chk (
  .clk_v      (clk_v),
  .rst_v      (rst_n_v),
  .en_vec     (en_vec),
  .tgt        (tgt_src),
  .loaded     (loaded_q),
  .sec_en_s   (sec_en_s),
  .ost_done   (ost_done),
  .pri_active (pri_active),
  .sec_active (sec_active)
);

// File: tb/sysclk_switch_tb.sv
`timescale 1ns/1ps
module sysclk_switch_tb;

  localparam real INT_PERIOD = 20.0;
  localparam real PRI_PERIOD = 8.0;
  localparam real SEC_PERIOD = 62.0;
  localparam real MIN_HALF   = 4.0;
  localparam int  OST        = 256;
  localparam real SETTLE     = 1500.0;
  localparam real WD_NS      = 150000.0;

  logic       clk_int, clk_pri, clk_sec;
  logic       por_n;
  logic [1:0] sel;
  logic       pri_default, sec_osc_en, cfg_loaded;
  logic       sys_clk, pri_active, sec_active;

  int checks, fails, glitches, overlaps;
  bit mon_on, done;
  realtime t_last_edge, t_rise, t_prev_rise;

  sysclk_switch #(.SYNC_STAGES(2), .OST_CYCLES(OST)) u_dut (
    .clk_int     (clk_int),
    .clk_pri     (clk_pri),
    .clk_sec     (clk_sec),
    .por_n       (por_n),
    .sel         (sel),
    .pri_default (pri_default),
    .sec_osc_en  (sec_osc_en),
    .cfg_loaded  (cfg_loaded),
    .sys_clk     (sys_clk),
    .pri_active  (pri_active),
    .sec_active  (sec_active)
  );

  initial begin clk_int = 0; forever #(INT_PERIOD/2.0) clk_int = ~clk_int; end
  initial begin clk_pri = 0; #1.3; forever #(PRI_PERIOD/2.0) clk_pri = ~clk_pri; end
  initial begin clk_sec = 0; #3.7; forever #(SEC_PERIOD/2.0) clk_sec = ~clk_sec; end

  // Phase-width monitor (R7).
  always @(sys_clk) begin
    if (mon_on && (($realtime - t_last_edge) < (MIN_HALF - 0.001))) glitches++;
    t_last_edge = $realtime;
    if (sys_clk) begin
      t_prev_rise = t_rise;
      t_rise = $realtime;
    end
  end

  // Flag overlap monitor (R8).
  always @(negedge clk_int) begin
    if (mon_on && pri_active && sec_active) overlaps++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  function automatic real period_of(input int src);
    return (src == 1) ? PRI_PERIOD : (src == 2) ? SEC_PERIOD : INT_PERIOD;
  endfunction

  // Identify the driving source from the last full period and the flags.
  task automatic expect_src(input int src, input string req);
    real per, age, exp_p;
    exp_p = period_of(src);
    per = t_rise - t_prev_rise;
    age = $realtime - t_rise;
    check((per > exp_p - 0.01) && (per < exp_p + 0.01) && (age <= exp_p + 0.01),
          req, "period", per, exp_p);
    check((pri_active == (src == 1)) && (sec_active == (src == 2)), req, "flags",
          real'({sec_active, pri_active}), real'((src == 1) ? 1 : (src == 2) ? 2 : 0));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(WD_NS);
    fails++;
    $display("FAIL R7 watchdog actual=%0.1f expected=%0.1f", WD_NS, 0.0);
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; glitches = 0; overlaps = 0;
    mon_on = 0; done = 0;
    t_last_edge = 0; t_rise = 0; t_prev_rise = 0;
    por_n = 0; sel = 2'b01; pri_default = 1; sec_osc_en = 1; cfg_loaded = 0;
    #95;
    // R1: reset state
    check(!sys_clk && !pri_active && !sec_active, "R1", "reset outputs",
          real'({sys_clk, sec_active, pri_active}), 0.0);
    #5;
    por_n = 1;
    t_last_edge = $realtime;
    mon_on = 1;
    #400;
    // R1: not loaded yet, secondary requested but internal must run
    expect_src(0, "R1");

    // R6: request primary before its start-up timer has run out
    sel = 2'b00; pri_default = 1; cfg_loaded = 1;
    #1000;
    check(!pri_active && (($realtime - t_last_edge) >= 300.0), "R6", "paused before timer",
          $realtime - t_last_edge, 300.0);
    #2000;
    expect_src(1, "R6");

    // Sweep every config / select / enable combination from a primary base.
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 4; s++) begin
        for (int e = 0; e < 2; e++) begin
          int exp_src;
          string tag;
          sel = 2'b00; pri_default = 1; sec_osc_en = 1;
          #(SETTLE);
          pri_default = c[0]; sel = s[1:0]; sec_osc_en = e[0];
          #(SETTLE);
          if (s == 0) begin
            exp_src = c ? 1 : 0; tag = "R2";
          end else if (s == 1) begin
            exp_src = e ? 2 : 1; tag = e ? "R3" : "R5";
          end else begin
            exp_src = 0; tag = "R4";
          end
          expect_src(exp_src, tag);
        end
      end
    end

    check(glitches == 0, "R7", "short phases", real'(glitches), 0.0);
    check(overlaps == 0, "R8", "flag overlap", real'(overlaps), 0.0);
    finish_run();
  end

endmodule